// File: doc/BRIEF.md
# 24-bit System Tick Timer

A memory-mapped periodic timer that counts down from a programmable start value and signals software each time the count runs out. Three word registers sit behind a single-cycle register port: a control/status word, a reload word and a current-count word. When the timer is enabled, each tick lowers the count by one. A tick is either every clock cycle or each pulse on a reference-tick input, as software selects. When the count reaches zero, the next tick reloads it from the reload word.

The count event happens on the step from one to zero. That step sets a sticky count flag, which software sees in the control/status word. If interrupts are enabled, the same step also produces a one-cycle interrupt pulse. Reading the control/status word clears the flag. Writing any value to the current-count word zeroes the count and clears the flag, so the next tick starts a fresh period. A reload value of zero keeps the timer inert: the count never passes from one to zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status word, the reload word and the current-count word all read 0, and irq is 0.
- R2: While the enable bit (control bit 0) is 1, each tick lowers a nonzero count by one. While the enable bit is 0, the count holds its value whatever the tick inputs do.
- R3: A tick that finds the count at zero loads the reload value into the count.
- R4: A tick that takes the count from 1 to 0 sets the count flag (control/status read bit 16). In the same edge, irq rises for exactly one clock cycle if the interrupt-enable bit (control bit 1) is 1. If that bit is 0, irq stays 0.
- R5: With a reload value of 0, ticks leave the count at 0, never set the flag and never raise irq.
- R6: A write of any value to the current-count word (byte offset 0x8) sets the count to 0 and clears the count flag.
- R7: A read of the control/status word (byte offset 0x0, with regRdEn) returns the flag as it stands, then clears it on that clock edge. A count event on the same edge takes precedence and leaves the flag set.
- R8: With the source bit (control bit 2) at 1, every clock cycle is a tick. With it at 0, only clock cycles in which refTick is 1 are ticks.
- R9: The reload word (byte offset 0x4) stores the 24 written bits. Reads of the reload and current-count words return the value zero-extended to 32 bits. Control/status reads return bits 2..0 as written, bit 16 as the flag and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference tick pulse, used when the source bit is 0 |
| regAddr | input | 4 | Register byte offset: 0x0 control/status, 0x4 reload, 0x8 current count |
| regWrEn | input | 1 | Write strobe, acts on the rising clock edge |
| regWrData | input | 24 | Write data |
| regRdEn | input | 1 | Read strobe; marks a read for side effects |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irq | output | 1 | One-cycle tick interrupt pulse |

## Verification
A corrupted count register is visible on the very next read of the current-count word. It also shifts the cycle in which the flag and irq appear by the size of the error, so one full period shows it. A flag stuck set or cleared shows in the next control/status read. A lost read-clear shows up as bit 16 still set on a second consecutive read. An interrupt that is gated wrongly or stretched shows within one cycle of the 1-to-0 step, as an irq pulse that is missing, extra or too long.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Register byte offsets on the register port
  localparam logic [3:0] OFS_CTRL   = 4'h0;
  localparam logic [3:0] OFS_RELOAD = 4'h4;
  localparam logic [3:0] OFS_CUR    = 4'h8;

  // Control bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_INTEN = 1;
  localparam int BIT_SRC   = 2;
  localparam int BIT_FLAG  = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic tickNow;    // a counting tick on this edge
    logic clrCount;   // write to the current-count word
    logic flagRdClr;  // read of the control/status word
    logic intEn;      // interrupt enable
  } tickStrobes_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic              regRdEn,
  input  logic [CNT_W-1:0]  count,
  input  logic              flag,
  output tickStrobes_t      strb,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [DATA_W-1:0] regRdData
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic enBit, intEnBit, srcBit;
  logic selCtrl, selReload, selCur;

  assign selCtrl   = (regAddr == ADDR_W'(OFS_CTRL));
  assign selReload = (regAddr == ADDR_W'(OFS_RELOAD));
  assign selCur    = (regAddr == ADDR_W'(OFS_CUR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      intEnBit  <= 1'b0;
      srcBit    <= 1'b0;
      reloadVal <= '0;
    end else if (regWrEn) begin
      if (selCtrl) begin
        enBit    <= regWrData[BIT_EN];
        intEnBit <= regWrData[BIT_INTEN];
        srcBit   <= regWrData[BIT_SRC];
      end
      if (selReload) reloadVal <= regWrData;
    end
  end

  always_comb begin
    strb.tickNow   = enBit && (srcBit || refTick);
    strb.clrCount  = regWrEn && selCur;
    strb.flagRdClr = regRdEn && selCtrl;
    strb.intEn     = intEnBit;
  end

  always_comb begin
    regRdData = '0;
    if (selCtrl) begin
      regRdData[BIT_EN]    = enBit;
      regRdData[BIT_INTEN] = intEnBit;
      regRdData[BIT_SRC]   = srcBit;
      regRdData[BIT_FLAG]  = flag;
    end else if (selReload) begin
      regRdData = {{PAD_W{1'b0}}, reloadVal};
    end else if (selCur) begin
      regRdData = {{PAD_W{1'b0}}, count};
    end
  end

  // R8
  ref_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcBit && !refTick) |-> !strb.tickNow);

  // R9
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selReload || selCur) |-> (regRdData[DATA_W-1:CNT_W] == '0));
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobes_t     strb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic hitZero;
  assign hitZero = strb.tickNow && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      flag  <= 1'b0;
      irq   <= 1'b0;
    end else if (strb.clrCount) begin
      count <= '0;
      flag  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (strb.tickNow) count <= (count == '0) ? reloadVal : count - ONE;
      flag <= hitZero || (flag && !strb.flagRdClr);
      irq  <= hitZero && strb.intEn;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tickNow && !strb.clrCount) |=> $stable(count));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tickNow && !strb.clrCount && count == '0) |=> (count == $past(reloadVal)));

  // R4
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R4
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flag && count == '0));

  // R6
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCount |=> (count == '0 && !flag));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagRdClr && !strb.tickNow && !strb.clrCount) |=> !flag);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  tickStrobes_t     strb;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] count;
  logic             flag;

  tick_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .count(count), .flag(flag), .strb(strb), .reloadVal(reloadVal),
    .regRdData(regRdData)
  );

  tick_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .count(count), .flag(flag), .irq(irq)
  );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic        regWrEn = 1'b0;
  logic [23:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int irqCount = 0;
  bit done = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_REL = 4'h4, A_CUR = 4'h8;

  always #5 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .refTick(refTick), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .irq(irq)
  );

  always @(negedge clk) if (irq) irqCount++;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [23:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    refTick = 1'b1;
    @(negedge clk);
    refTick = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_REL, d);  chk("R1 reload", d, 32'h0);
    rd(A_CUR, d);  chk("R1 current", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic test_count_flag();
    logic [31:0] d;
    wr(A_REL, 24'd3);
    wr(A_CTRL, 24'h1);
    repeat (3) @(negedge clk);
    rd(A_CUR, d); chk("R8 no tick without refTick", d, 32'h0);
    tick(); rd(A_CUR, d); chk("R3 load on zero", d, 32'd3);
    tick(); rd(A_CUR, d); chk("R2 decrement", d, 32'd2);
    tick(); tick();
    rd(A_CUR, d); chk("R4 reached zero", d, 32'd0);
    chk("R4 irq off when gated", irqCount, 0);
    rd(A_CTRL, d); chk("R7 flag seen", d, 32'h0001_0001);
    rd(A_CTRL, d); chk("R7 flag cleared by read", d, 32'h0000_0001);
  endtask

  task automatic test_irq();
    logic [31:0] d;
    int base;
    wr(A_CTRL, 24'h3);
    base = irqCount;
    tick(); tick(); tick();
    chk("R4 no irq before event", irqCount - base, 0);
    tick();
    #1 chk("R4 irq high after 1-to-0", {31'b0, irq}, 32'h1);
    @(negedge clk); #1 chk("R4 irq drops", {31'b0, irq}, 32'h0);
    chk("R4 single pulse", irqCount - base, 1);
    rd(A_CTRL, d); chk("R4 flag set", d, 32'h0001_0003);
  endtask

  task automatic test_hold();
    logic [31:0] d;
    tick(); tick();
    rd(A_CUR, d); chk("R2 count before hold", d, 32'd2);
    wr(A_CTRL, 24'h2);
    tick(); tick();
    rd(A_CUR, d); chk("R2 held while disabled", d, 32'd2);
  endtask

  task automatic test_write_clear();
    logic [31:0] d;
    wr(A_CTRL, 24'h3);
    tick(); tick();
    wr(A_CUR, 24'hABC);
    rd(A_CUR, d); chk("R6 count zeroed", d, 32'd0);
    rd(A_CTRL, d); chk("R6 flag cleared by write", d, 32'h3);
  endtask

  task automatic test_zero_reload();
    logic [31:0] d;
    int base;
    wr(A_REL, 24'd0);
    base = irqCount;
    tick(); tick(); tick();
    rd(A_CUR, d); chk("R5 inert count", d, 32'd0);
    rd(A_CTRL, d); chk("R5 no flag", d, 32'h3);
    chk("R5 no irq", irqCount - base, 0);
  endtask

  task automatic test_max_reload();
    logic [31:0] d;
    wr(A_REL, 24'hFFFFFF);
    rd(A_REL, d); chk("R9 reload readback", d, 32'h00FF_FFFF);
    tick(); rd(A_CUR, d); chk("R3 max load", d, 32'h00FF_FFFF);
    tick(); rd(A_CUR, d); chk("R2 max decrement", d, 32'h00FF_FFFE);
  endtask

  task automatic test_clock_source();
    int base;
    wr(A_CTRL, 24'h0);
    wr(A_CUR, 24'h0);
    wr(A_REL, 24'd4);
    base = irqCount;
    wr(A_CTRL, 24'h7);
    regAddr = A_CUR;
    @(negedge clk); @(negedge clk);
    #1 chk("R8 every clock counts", regRdData, 32'd3);
    repeat (4) @(negedge clk);
    #1 chk("R8 reload after period", regRdData, 32'd4);
    chk("R8 one irq per period", irqCount - base, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_count_flag();
    test_irq();
    test_hold();
    test_write_clear();
    test_zero_reload();
    test_max_reload();
    test_clock_source();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule